// File: doc/BRIEF.md
# Table-Seeded Newton-Raphson Reciprocal

The block computes z = 1/v for an unsigned fixed-point operand v in [1, 2). The operand has one integer bit and fifteen fraction bits. A lookup table gives a first estimate of the reciprocal. The table is indexed by the ten most significant fraction bits of v and its contents are calculated during elaboration. One Newton-Raphson refinement, z1 = 2*z0 - v*z0^2, then sharpens that estimate to close to full output precision. The refinement uses one squaring multiplier, one general multiplier, one subtractor and one rounding adder.

The datapath is a four-stage pipeline and accepts an operand on every clock. A valid flag travels with each operand. The matching result appears with its own valid flag exactly four cycles later. The result has the same format as the operand (1 integer bit, 15 fraction bits) and always lies between 0.5 and 1.0 inclusive. The intended use is the mantissa stage of a wider divider or normaliser, which supplies operands already scaled into [1, 2).

Top module: `nr_recip`

## Requirements
- R1: `out_vld` equals the value of `in_vld` sampled four rising edges earlier, so the latency is fixed at 4 cycles.
- R2: For every input code v_code from 0x8000 to 0xFFFF, the output satisfies |out_z/2^15 - 2^15/v_code| < 2^-14.
- R3: The input code 0x8000 (v = 1.0) gives exactly 0x8000 (z = 1.0).
- R4: Every valid output code lies in the range 0x4000 to 0x8000 inclusive.
- R5: Operands presented on consecutive cycles each produce their own correct result on consecutive cycles, with no stall or bubble.
- R6: While `in_vld` is low the value on `in_v` has no effect: the cycle yields `out_vld` low four cycles later, and the results of valid operands around it are unchanged.
- R7: Synchronous active-high reset discards every operand in flight. `out_vld` is low from the first edge with reset high until a new valid operand has passed through all four stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operand qualifier |
| in_v | input | 16 | Operand, unsigned Q1.15, bit 15 set |
| out_vld | output | 1 | Result qualifier, four cycles after `in_vld` |
| out_z | output | 16 | Reciprocal, unsigned Q1.15, 0x4000 to 0x8000 |

## Verification
A wrong seed table entry shows up as a result error on the 32 input codes that share that entry, four cycles after one of them is presented. The exhaustive sweep therefore exposes such an entry within the 32768 consecutive results. A misaligned pipeline register either moves `out_vld` off the four-cycle slot or pairs the estimate of one operand with the v of its neighbour. The pairing error is large whenever adjacent operands differ, so the first valid result after the fault departs from the real-number reciprocal. A rounding or truncation error in the refinement leaves the result close to correct. The tolerance in R2 is set only a few LSBs above the error budget so that such errors still show at the ports.

// File: rtl/nr_recip_pkg.sv
package nr_recip_pkg;

    // Operand and result formats
    localparam int IN_W      = 16;
    localparam int IN_FRAC   = 15;
    localparam int OUT_W     = 16;
    localparam int OUT_FRAC  = 15;

    // Seed table geometry
    localparam int SEED_AW   = 10;
    localparam int SEED_W    = 10;
    localparam int SEED_DEPTH = 1 << SEED_AW;

    // Guard precision of the refinement products
    localparam int GRD_FRAC  = 18;

    // Derived widths and shifts
    localparam int Z0_W       = SEED_W + 1;           // seed with hidden leading one
    localparam int Z0_FRAC    = SEED_W + 1;
    localparam int SQ_W       = GRD_FRAC;             // z0^2 < 1
    localparam int SQ_SHIFT   = 2 * Z0_FRAC - GRD_FRAC;
    localparam int PR_W       = GRD_FRAC + 1;         // v*z0^2 < 2
    localparam int PR_SHIFT   = IN_FRAC;
    localparam int DF_W       = GRD_FRAC + 2;
    localparam int TWOZ_SHIFT = GRD_FRAC - Z0_FRAC + 1;
    localparam int RND_SHIFT  = GRD_FRAC - OUT_FRAC;
    localparam int ADDR_LSB   = IN_FRAC - SEED_AW;
    localparam int LATENCY    = 4;

    localparam logic [IN_W-1:0]  IN_ONE  = IN_W'(1) << IN_FRAC;
    localparam logic [OUT_W-1:0] OUT_ONE = OUT_W'(1) << OUT_FRAC;

    typedef logic [SEED_W-1:0] seed_tab_t [SEED_DEPTH];

    typedef struct packed {
        logic            vld;
        logic [IN_W-1:0] v;
    } opnd_t;

    typedef struct packed {
        logic            vld;
        logic [IN_W-1:0] v;
        logic [Z0_W-1:0] z0;
    } carry_t;

    // Entry a holds 1/m rounded to SEED_W+1 fraction bits with the leading
    // one dropped, where m is the midpoint of interval a:
    // m = (2^(A+1) + 2a + 1) / 2^(A+1).
    function automatic seed_tab_t build_seed_tab();
        seed_tab_t tab;
        longint    num;
        longint    den;
        longint    q;
        num = longint'(1) << (SEED_W + SEED_AW + 3);
        for (int a = 0; a < SEED_DEPTH; a++) begin
            den = (longint'(1) << (SEED_AW + 1)) + 2 * longint'(a) + 1;
            q   = ((num / den) + 1) >>> 1;
            if (q > (longint'(1) << (SEED_W + 1)) - 1)
                q = (longint'(1) << (SEED_W + 1)) - 1;
            q = q - (longint'(1) << SEED_W);
            tab[a] = SEED_W'(q);
        end
        return tab;
    endfunction

endpackage

// File: rtl/nr_seed_rom.sv
module nr_seed_rom
    import nr_recip_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [SEED_AW-1:0] addr,
    output logic [Z0_W-1:0]    z0
);
    localparam seed_tab_t TAB = build_seed_tab();

    always_ff @(posedge clk) begin
        if (rst) z0 <= '0;
        else     z0 <= {1'b1, TAB[addr]};
    end
endmodule

// File: rtl/nr_mul_trunc.sv
module nr_mul_trunc #(
    parameter int AW    = 11,
    parameter int BW    = 11,
    parameter int SHIFT = 4,
    parameter int OW    = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [OW-1:0] p
);
    localparam int FW = AW + BW;

    logic [FW-1:0] full;
    assign full = FW'(a) * FW'(b);

    generate
        if (SHIFT > 0) begin : g_drop
            logic unused_low;
            assign unused_low = ^full[SHIFT-1:0];
        end
        if (SHIFT + OW < FW) begin : g_top
            logic unused_high;
            assign unused_high = ^full[FW-1:SHIFT+OW];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) p <= '0;
        else     p <= full[SHIFT +: OW];
    end
endmodule

// File: rtl/nr_finish.sv
module nr_finish
    import nr_recip_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  carry_t           cin,
    input  logic [PR_W-1:0]  prod,
    output logic             vld,
    output logic [OUT_W-1:0] z
);
    logic [DF_W-1:0] twoz;
    logic [DF_W-1:0] diff;
    logic [DF_W-1:0] rnd;
    logic [OUT_W-1:0] res;

    always_comb begin
        twoz = DF_W'(cin.z0) << TWOZ_SHIFT;
        diff = twoz - DF_W'(prod);
        rnd  = (diff + (DF_W'(1) << (RND_SHIFT - 1))) >> RND_SHIFT;
        if (cin.v == IN_ONE || rnd > DF_W'(OUT_ONE))
            res = OUT_ONE;
        else
            res = rnd[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= 1'b0;
            z   <= '0;
        end else begin
            vld <= cin.vld;
            z   <= res;
        end
    end
endmodule

// File: rtl/nr_recip.sv
module nr_recip
    import nr_recip_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [IN_W-1:0]  in_v,
    output logic             out_vld,
    output logic [OUT_W-1:0] out_z
);
    opnd_t            op_a;
    logic [Z0_W-1:0]  z0_a;
    carry_t           cr_b;
    carry_t           cr_c;
    logic [SQ_W-1:0]  sq_b;
    logic [PR_W-1:0]  pr_c;

    // Stage A: seed lookup
    nr_seed_rom u_rom (
        .clk  (clk),
        .rst  (rst),
        .addr (in_v[ADDR_LSB +: SEED_AW]),
        .z0   (z0_a)
    );

    always_ff @(posedge clk) begin
        if (rst) op_a <= '0;
        else     op_a <= '{vld: in_vld, v: in_v};
    end

    // Stage B: z0 squared
    nr_mul_trunc #(.AW(Z0_W), .BW(Z0_W), .SHIFT(SQ_SHIFT), .OW(SQ_W)) u_sq (
        .clk (clk),
        .rst (rst),
        .a   (z0_a),
        .b   (z0_a),
        .p   (sq_b)
    );

    always_ff @(posedge clk) begin
        if (rst) cr_b <= '0;
        else     cr_b <= '{vld: op_a.vld, v: op_a.v, z0: z0_a};
    end

    // Stage C: v * z0^2
    nr_mul_trunc #(.AW(IN_W), .BW(SQ_W), .SHIFT(PR_SHIFT), .OW(PR_W)) u_vp (
        .clk (clk),
        .rst (rst),
        .a   (cr_b.v),
        .b   (sq_b),
        .p   (pr_c)
    );

    always_ff @(posedge clk) begin
        if (rst) cr_c <= '0;
        else     cr_c <= cr_b;
    end

    // Stage D: 2*z0 - v*z0^2, round, saturate
    nr_finish u_fin (
        .clk  (clk),
        .rst  (rst),
        .cin  (cr_c),
        .prod (pr_c),
        .vld  (out_vld),
        .z    (out_z)
    );
endmodule

// File: rtl/nr_recip_chk.sv
module nr_recip_chk
    import nr_recip_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_vld,
    input logic [IN_W-1:0]  in_v,
    input logic             out_vld,
    input logic [OUT_W-1:0] out_z
);
    logic [2:0] warm_cnt;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst)                       warm_cnt <= '0;
        else if (warm_cnt < LATENCY)   warm_cnt <= warm_cnt + 3'd1;
    end
    assign warm = (warm_cnt >= LATENCY);

    AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_vld == $past(in_vld, 4)));                              // R1

    AST_RESULT_KNOWN: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> !$isunknown(out_z));                                      // R2

    AST_UNITY_EXACT: assert property (@(posedge clk) disable iff (rst)
        (warm && out_vld && $past(in_v, 4) == IN_ONE) |-> out_z == OUT_ONE);  // R3

    AST_OUT_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (out_z <= OUT_ONE && out_z >= (OUT_ONE >> 1)));          // R4

    AST_IDLE_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_vld);                                             // R7
endmodule

bind nr_recip nr_recip_chk u_chk (.*);

// File: tb/nr_recip_bench.sv
module nr_recip_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [15:0] in_v = 16'h8000;
    logic        out_vld;
    logic [15:0] out_z;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    nr_recip u_nr_recip (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_v(in_v),
        .out_vld(out_vld), .out_z(out_z)
    );

    // Reference: four-deep delay of {vld, v}, cleared by reset
    bit [16:0] mdl[$] = '{17'd0, 17'd0, 17'd0, 17'd0};

    always @(posedge clk) begin
        if (rst) mdl = '{17'd0, 17'd0, 17'd0, 17'd0};
        else begin
            mdl.push_front({in_vld, in_v});
            void'(mdl.pop_back());
        end
    end

    task automatic report(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Per-cycle compare, away from the active edge
    always @(negedge clk) begin
        bit        e_vld;
        bit [15:0] e_v;
        real       ideal;
        real       err;
        cycles++;
        e_vld = mdl[3][16];
        e_v   = mdl[3][15:0];
        if (!rst) begin
            report(out_vld == e_vld, "R1/R6/R7 out_vld", longint'(out_vld), longint'(e_vld));
            if (e_vld && out_vld) begin
                ideal = 32768.0 / real'(e_v);
                err   = real'(out_z) / 32768.0 - ideal;
                if (err < 0.0) err = -err;
                report(err < (1.0 / 16384.0), "R2/R5 accuracy", longint'(out_z),
                       longint'(ideal * 32768.0 + 0.5));
                report(out_z >= 16'h4000 && out_z <= 16'h8000, "R4 range",
                       longint'(out_z), 64'h8000);
                if (e_v == 16'h8000)
                    report(out_z == 16'h8000, "R3 unity", longint'(out_z), 64'h8000);
            end
        end
        if (cycles > 200000 && !finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 200000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic drive(input bit vld, input logic [15:0] v);
        @(negedge clk);
        in_vld = vld;
        in_v   = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        report(out_vld == 1'b0, "R7 reset state", longint'(out_vld), 0);
        @(negedge clk);
        rst = 1'b0;

        // R3: unity alone, then idle
        drive(1'b1, 16'h8000);
        drive(1'b0, 16'h1234);
        repeat (5) drive(1'b0, 16'hFFFF);

        // R2, R5: exhaustive back-to-back sweep
        for (int c = 32768; c < 65536; c++) drive(1'b1, 16'(c));

        // R6: alternating gaps with junk operand values
        for (int k = 0; k < 200; k++) begin
            drive(1'b1, 16'(16'h8000 + k * 157));
            drive(1'b0, 16'(k * 7919));
            drive(1'b0, 16'h0000);
        end
        drive(1'b1, 16'hFFFF);
        drive(1'b1, 16'h8001);
        drive(1'b1, 16'hC000);

        // R7: reset with operands in flight
        drive(1'b1, 16'hA000);
        drive(1'b1, 16'hB000);
        @(negedge clk);
        rst = 1'b1;
        in_vld = 1'b1;
        in_v   = 16'hE000;
        @(negedge clk);
        report(out_vld == 1'b0, "R7 flush", longint'(out_vld), 0);
        rst = 1'b0;
        in_vld = 1'b0;
        repeat (3) drive(1'b0, 16'h9000);
        drive(1'b1, 16'h8000);
        drive(1'b1, 16'hAAAA);
        repeat (8) drive(1'b0, 16'h0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule